// File: doc/BRIEF.md
# Dual-Class Interrupt Mask Controller

This block gathers two groups of level-sensitive interrupt sources, a normal class and a fast class, and turns each group into a single request line for a processor. Each class has its own enable mask. A class line is high while any source in that class is both active and enabled.

Software reaches the block through a simple single-cycle register port. The mask of a class cannot be written directly. It is changed only by writing ones to a set location or to a clear location, so two agents can change different mask bits without a read-modify-write race. For each class, software can read the unfiltered source levels and the filtered view separately.

Address bit 2 selects the class: 0 is the normal class and 1 is the fast class. Address bits [1:0] select the function:
- 0: filtered status, read-only.
- 1: raw source levels, read-only.
- 2: enable-set. A read returns the mask.
- 3: enable-clear. A read returns the mask.

Read data appears on `bus_rdata` in the cycle after the read strobe. In every other cycle `bus_rdata` is zero.

Top module: `dual_class_intc`

## Requirements
- R1: While reset is held and directly after it, both enable masks are zero, `irq_o`, `fiq_o` and `bus_err` are low, and `bus_rdata` is zero.
- R2: A read at function 0 of a class returns, one cycle later, that class's source levels ANDed with its enable mask.
- R3: A read at function 1 of a class returns, one cycle later, that class's unmasked source levels.
- R4: A write at function 2 ORs the write data into that class's mask. A read at function 2 or 3 returns the mask.
- R5: A write at function 3 clears each mask bit whose write data bit is 1 and leaves every other mask bit unchanged.
- R6: The fast class (address bit 2 = 1) behaves exactly like the normal class. A mask write to one class leaves the other class's mask unchanged.
- R7: A write at function 0 or 1 of either class leaves both masks unchanged and raises `bus_err` for exactly the following cycle.
- R8: `irq_o` is high exactly when some normal-class source is high with its mask bit set. `fiq_o` is formed the same way from the fast class.
- R9: Reads and mask writes never raise `bus_err`, and reads never change a mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | DW | Normal-class source levels |
| src_fiq | input | DW | Fast-class source levels |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Bit 2 selects the class, bits [1:0] select the function |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid the cycle after a read, zero otherwise |
| bus_err | output | 1 | One-cycle pulse after a write to a read-only location |
| irq_o | output | 1 | Normal-class request |
| fiq_o | output | 1 | Fast-class request |

## Verification
The hardest situation to reach from the ports is one where the two classes must be told apart. A defect that swaps or merges the class decode looks correct as long as both masks hold the same value.

The stimulus therefore first loads very different masks into the two classes. It then writes to one class and checks that the other class's mask reads back unchanged. After that it drives sources that overlap only one of the two masks and confirms that only the matching request line rises.

Writes to the read-only locations are issued with all-ones data, so that any leak into a mask would show up on readback.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NCLASS  = 2;
  localparam int ADDR_W  = 3;
  localparam int CLS_BIT = 2;

  typedef enum logic [1:0] {
    FN_MASKED = 2'd0,
    FN_RAW    = 2'd1,
    FN_ENSET  = 2'd2,
    FN_ENCLR  = 2'd3
  } fn_e;
endpackage

// File: rtl/intc_decode.sv
module intc_decode
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NCLASS-1:0] set_stb,
  output logic [NCLASS-1:0] clr_stb,
  output logic              rd_stb,
  output logic              rd_cls,
  output fn_e               rd_fn,
  output logic              err_q
);
  fn_e  fn;
  logic cls;
  logic ro_wr;
  logic err_d;

  assign fn     = fn_e'(bus_addr[1:0]);
  assign cls    = bus_addr[CLS_BIT];
  assign rd_stb = bus_sel && !bus_we;
  assign rd_cls = cls;
  assign rd_fn  = fn;

  for (genvar c = 0; c < NCLASS; c++) begin : g_cls
    assign set_stb[c] = bus_sel && bus_we && (cls == c[0]) && (fn == FN_ENSET);
    assign clr_stb[c] = bus_sel && bus_we && (cls == c[0]) && (fn == FN_ENCLR);
  end

  always_comb begin
    ro_wr = bus_sel && bus_we && ((fn == FN_MASKED) || (fn == FN_RAW));
    err_d = ro_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end
endmodule

// File: rtl/intc_class_bank.sv
module intc_class_bank #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] src,
  input  logic          set_stb,
  input  logic          clr_stb,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] masked,
  output logic          line
);
  logic [DW-1:0] mask_d;
  logic          mask_en;

  always_comb begin
    mask_en = set_stb || clr_stb;
    mask_d  = mask_q;
    if (set_stb)      mask_d = mask_q | wdata;
    else if (clr_stb) mask_d = mask_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign masked = src & mask_q;
  assign line   = |masked;
endmodule

// File: rtl/intc_rdmux.sv
module intc_rdmux
  import intc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_stb,
  input  logic                      rd_cls,
  input  fn_e                       rd_fn,
  input  logic [NCLASS-1:0][DW-1:0] raw,
  input  logic [NCLASS-1:0][DW-1:0] masked,
  input  logic [NCLASS-1:0][DW-1:0] mask,
  output logic [DW-1:0]             rdata_q
);
  logic [DW-1:0] rdata_d;

  always_comb begin
    rdata_d = '0;
    if (rd_stb) begin
      unique case (rd_fn)
        FN_MASKED: rdata_d = masked[rd_cls];
        FN_RAW:    rdata_d = raw[rd_cls];
        default:   rdata_d = mask[rd_cls];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end
endmodule

// File: rtl/dual_class_intc.sv
module dual_class_intc
  import intc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     src_irq,
  input  logic [DW-1:0]     src_fiq,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_err,
  output logic              irq_o,
  output logic              fiq_o
);
  logic [NCLASS-1:0]         set_stb, clr_stb;
  logic                      rd_stb, rd_cls;
  fn_e                       rd_fn;
  logic [NCLASS-1:0][DW-1:0] raw_all, masked_all, mask_all;
  logic [NCLASS-1:0]         line_all;
  logic [DW-1:0]             irq_mask_w, fiq_mask_w;

  assign raw_all[0] = src_irq;
  assign raw_all[1] = src_fiq;

  intc_decode u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_sel (bus_sel),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .set_stb (set_stb),
    .clr_stb (clr_stb),
    .rd_stb  (rd_stb),
    .rd_cls  (rd_cls),
    .rd_fn   (rd_fn),
    .err_q   (bus_err)
  );

  for (genvar c = 0; c < NCLASS; c++) begin : g_bank
    intc_class_bank #(.DW(DW)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .src    (raw_all[c]),
      .set_stb(set_stb[c]),
      .clr_stb(clr_stb[c]),
      .wdata  (bus_wdata),
      .mask_q (mask_all[c]),
      .masked (masked_all[c]),
      .line   (line_all[c])
    );
  end

  intc_rdmux #(.DW(DW)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_stb (rd_stb),
    .rd_cls (rd_cls),
    .rd_fn  (rd_fn),
    .raw    (raw_all),
    .masked (masked_all),
    .mask   (mask_all),
    .rdata_q(bus_rdata)
  );

  assign irq_o      = line_all[0];
  assign fiq_o      = line_all[1];
  assign irq_mask_w = mask_all[0];
  assign fiq_mask_w = mask_all[1];
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [2:0]    bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          bus_err,
  input logic [DW-1:0] src_irq,
  input logic [DW-1:0] src_fiq,
  input logic          irq_o,
  input logic          fiq_o,
  input logic [DW-1:0] irq_mask,
  input logic [DW-1:0] fiq_mask
);
  logic ro_write, any_write;
  assign ro_write  = bus_sel && bus_we && !bus_addr[1];
  assign any_write = bus_sel && bus_we;

  // R7
  status_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ro_write |=> bus_err);

  // R9
  no_spurious_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ro_write |=> !bus_err);

  // R7
  status_write_keeps_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ro_write |=> ($stable(irq_mask) && $stable(fiq_mask)));

  // R9
  read_keeps_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_write |=> ($stable(irq_mask) && $stable(fiq_mask)));

  // R4
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_write && bus_addr == 3'd2) |=> ((irq_mask & $past(bus_wdata)) == $past(bus_wdata)));

  // R5
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_write && bus_addr == 3'd3) |=> ((irq_mask & $past(bus_wdata)) == '0));

  // R6
  fiq_write_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_write && bus_addr[2]) |=> $stable(irq_mask));

  // R2
  irq_masked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == 3'd0) |=> (bus_rdata == $past(src_irq & irq_mask)));

  // R8
  irq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (src_irq != '0));

  // R8
  fiq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> (src_fiq != '0));
endmodule

bind dual_class_intc intc_checker #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .bus_err  (bus_err),
  .src_irq  (src_irq),
  .src_fiq  (src_fiq),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o),
  .irq_mask (irq_mask_w),
  .fiq_mask (fiq_mask_w)
);

// File: tb/dual_class_intc_tb.sv
`timescale 1ns/1ps
module dual_class_intc_tb;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] src_irq, src_fiq, bus_wdata, bus_rdata;
  logic          bus_sel, bus_we, bus_err, irq_o, fiq_o;
  logic [2:0]    bus_addr;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  dual_class_intc #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .src_fiq(src_fiq),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d, output logic err);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    err = bus_err;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    check("R1 rdata", bus_rdata, '0);
    check("R1 err", {31'd0, bus_err}, 32'd0);
    check("R1 irq_o", {31'd0, irq_o}, 32'd0);
    check("R1 fiq_o", {31'd0, fiq_o}, 32'd0);
    rd(3'd2, v); check("R1 irq mask", v, '0);
    rd(3'd6, v); check("R1 fiq mask", v, '0);
  endtask

  task automatic t_set_clear();
    logic [DW-1:0] v; logic e;
    wr(3'd2, 32'h0000_00F0, e); check("R9 set no err", {31'd0, e}, 32'd0);
    rd(3'd2, v); check("R4 first set", v, 32'h0000_00F0);
    wr(3'd2, 32'h0F00_0001, e);
    rd(3'd3, v); check("R4 or set", v, 32'h0F00_00F1);
    wr(3'd3, 32'h0000_0031, e); check("R9 clr no err", {31'd0, e}, 32'd0);
    rd(3'd2, v); check("R5 clear", v, 32'h0F00_00C0);
  endtask

  task automatic t_status();
    logic [DW-1:0] v;
    src_irq = 32'hFFFF_0040;
    rd(3'd1, v); check("R3 raw", v, 32'hFFFF_0040);
    rd(3'd0, v); check("R2 masked", v, 32'h0F00_0040);
    check("R8 irq high", {31'd0, irq_o}, 32'd1);
    rd(3'd2, v); check("R9 read keeps mask", v, 32'h0F00_00C0);
    src_irq = 32'h0000_0020; #1;
    check("R8 irq low", {31'd0, irq_o}, 32'd0);
    rd(3'd0, v); check("R2 masked zero", v, '0);
  endtask

  task automatic t_fiq();
    logic [DW-1:0] v; logic e;
    wr(3'd6, 32'h8000_0000, e);
    rd(3'd6, v); check("R6 fiq set", v, 32'h8000_0000);
    rd(3'd2, v); check("R6 irq untouched", v, 32'h0F00_00C0);
    check("R8 fiq low", {31'd0, fiq_o}, 32'd0);
    src_fiq = 32'h8000_0100; #1;
    check("R8 fiq high", {31'd0, fiq_o}, 32'd1);
    check("R6 irq stays low", {31'd0, irq_o}, 32'd0);
    rd(3'd4, v); check("R6 fiq masked", v, 32'h8000_0000);
    rd(3'd5, v); check("R6 fiq raw", v, 32'h8000_0100);
    wr(3'd7, 32'hFFFF_FFFF, e);
    check("R6 fiq cleared line", {31'd0, fiq_o}, 32'd0);
    rd(3'd7, v); check("R6 fiq mask zero", v, '0);
    rd(3'd3, v); check("R6 irq kept", v, 32'h0F00_00C0);
  endtask

  task automatic t_ro_write();
    logic [DW-1:0] v; logic e;
    wr(3'd0, 32'hFFFF_FFFF, e); check("R7 err pulse", {31'd0, e}, 32'd1);
    @(posedge clk); #1; check("R7 err single", {31'd0, bus_err}, 32'd0);
    rd(3'd2, v); check("R7 irq mask kept", v, 32'h0F00_00C0);
    wr(3'd5, 32'hFFFF_FFFF, e); check("R7 fiq err", {31'd0, e}, 32'd1);
    rd(3'd6, v); check("R7 fiq mask kept", v, '0);
    wr(3'd1, 32'hFFFF_FFFF, e);
    rd(3'd2, v); check("R7 raw write ignored", v, 32'h0F00_00C0);
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_wdata = '0; src_irq = '0; src_fiq = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset_pre: begin
      check("R1 in reset rdata", bus_rdata, '0);
    end
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_clear();
    t_status();
    t_fiq();
    t_ro_write();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule